// File: doc/BRIEF.md
# Digital Potentiometer Function Engine

This block is the function layer of a single-wire-bus digital potentiometer. It sits behind the byte-level bit engine and the addressing logic. Once addressing finishes, the addressing logic pulses an entry strobe. The block then takes one command byte and the data bytes that follow it. It answers master reads with response bytes.

It holds two registers, an 8-bit wiper code and an 8-bit control byte, and it can also report a fixed capability byte. Writes to either register use two phases. The block first echoes the data byte back to the master. It commits the value only if the next byte is the release code. Increment and decrement change the wiper by one step and stop at the ends of the range. After either of these, the block takes a new command byte directly.

The wiper code and the charge-pump enable go to the resistor array. A flag shows that the wiper still holds its power-on value, which a conditional search uses. A bus reset pulse aborts any command in progress and returns the block to waiting for entry.

Top module: `digipot_fn`

## Requirements
- R1: After rst_n, wiper_code is 00h, the control byte reads 0Ch, pump_en is 0, wiper_home is 1, and rd_valid is 0.
- R2: Command F0h makes the next read return the control byte and the read after it return the wiper code. Every later read returns 00h until bus_rst.
- R3: Command AAh makes the next read return the capability byte F3h and the read after it return the control byte. Every later read returns 00h until bus_rst.
- R4: Command 0Fh takes one data byte, and the next read echoes that byte. If the byte written after the echo is 96h, the wiper takes the data and later reads return 00h. Any other byte leaves the wiper unchanged and later reads return FFh. The wiper changes only in the cycle after a byte is written.
- R5: Command 55h takes a control byte. Only 0Ch and 4Ch are accepted. In the control byte, bit 6 drives pump_en, bits 1:0 select the wiper and bits 3:2 are their ones complement. For an accepted value the echo and the release rule of R4 apply. For any other value the echo is FFh, later reads return FFh, and the control byte never changes, even if 96h follows.
- R6: Command C3h raises the wiper by one, and the next read returns the new value. At FFh the wiper stays at FFh.
- R7: Command 99h lowers the wiper by one, and the next read returns the new value. At 00h the wiper stays at 00h.
- R8: After the read that completes an increment or a decrement, the next written byte is decoded as a new command.
- R9: bus_rst returns the block to idle and discards uncommitted write data. Committed values are kept. In idle, written bytes are ignored until fn_enter.
- R10: An unknown command byte makes every later read return FFh until bus_rst. Bytes written after it are ignored.
- R11: wiper_home is 1 exactly when wiper_code is 00h.
- R12: A read answers with rd_valid and rd_data in the cycle after rd_req. A read in idle, or in a state that expects a written byte, returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_rst | input | 1 | Bus reset pulse; aborts the current command |
| fn_enter | input | 1 | Addressing complete; start accepting a command byte |
| wr_valid | input | 1 | A byte from the master is present on wr_data |
| wr_data | input | 8 | Byte written by the master, in order received |
| rd_req | input | 1 | Master requests a response byte |
| rd_valid | output | 1 | Response byte valid, one cycle after rd_req |
| rd_data | output | 8 | Response byte |
| wiper_code | output | 8 | Wiper tap code to the resistor array |
| pump_en | output | 1 | Charge-pump enable (control bit 6) |
| wiper_home | output | 1 | Wiper is at its power-on value 00h |

## Verification
Some rules are checked by assertions on every cycle. The control byte must always be one of its two legal values. The wiper may move only after a written byte. An increment or decrement at the end of the range must leave the wiper where it is. A bus reset must always land the block in idle. An invalid control echo must read FFh, and every response must come one cycle after its request. The full command sequences can only be shown by the bench scenarios: byte order within each read command, commit versus reject on the release byte, keeping committed values across an aborted write, chaining commands after a step, and the ones-forever state after an unknown command.

// File: rtl/digipot_pkg.sv
package digipot_pkg;
  localparam logic [7:0] OP_RD_POS  = 8'hF0;
  localparam logic [7:0] OP_WR_POS  = 8'h0F;
  localparam logic [7:0] OP_RD_CTL  = 8'hAA;
  localparam logic [7:0] OP_WR_CTL  = 8'h55;
  localparam logic [7:0] OP_STEP_UP = 8'hC3;
  localparam logic [7:0] OP_STEP_DN = 8'h99;
  localparam logic [7:0] RELEASE    = 8'h96;
  localparam logic [7:0] CTL_PUMP_OFF = 8'h0C;
  localparam logic [7:0] CTL_PUMP_ON  = 8'h4C;
  localparam logic [7:0] CAPS_BYTE    = 8'hF3;
  localparam int unsigned PUMP_BIT    = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_RP_CTL, S_RP_WIP, S_RC_CAPS, S_RC_CTL,
    S_W_DATA, S_W_ECHO, S_W_REL, S_STEP_RD, S_TAIL0, S_TAIL1
  } fn_state_e;
endpackage

// File: rtl/digipot_regs.sv
module digipot_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit_wip,
  input  logic         commit_ctl,
  input  logic [W-1:0] commit_data,
  input  logic         step_up,
  input  logic         step_dn,
  output logic [W-1:0] wiper,
  output logic [W-1:0] ctrl
);
  import digipot_pkg::*;
  localparam logic [W-1:0] WMAX = {W{1'b1}};
  localparam logic [W-1:0] WMIN = '0;

  logic [W-1:0] wiper_n;
  logic         wiper_en;

  always_comb begin
    wiper_en = commit_wip | step_up | step_dn;
    wiper_n  = wiper;
    if (commit_wip)                      wiper_n = commit_data;
    else if (step_up && wiper != WMAX)   wiper_n = wiper + 1'b1;
    else if (step_dn && wiper != WMIN)   wiper_n = wiper - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wiper <= WMIN;
    else if (wiper_en) wiper <= wiper_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctrl <= W'(CTL_PUMP_OFF);
    else if (commit_ctl) ctrl <= commit_data;
  end

  p_ctrl_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == W'(CTL_PUMP_OFF)) || (ctrl == W'(CTL_PUMP_ON)));
  p_inc_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !commit_wip && wiper == WMAX) |=> (wiper == WMAX));
  p_dec_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !commit_wip && wiper == WMIN) |=> (wiper == WMIN));
endmodule

// File: rtl/digipot_seq.sv
module digipot_seq #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_rst,
  input  logic         fn_enter,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  input  logic [W-1:0] wiper,
  input  logic [W-1:0] ctrl,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         commit_wip,
  output logic         commit_ctl,
  output logic [W-1:0] commit_data,
  output logic         step_up,
  output logic         step_dn
);
  import digipot_pkg::*;
  localparam logic [W-1:0] ONES  = {W{1'b1}};
  localparam logic [W-1:0] ZEROS = '0;

  fn_state_e    st, st_n;
  logic [W-1:0] pend, pend_n;
  logic         pend_ctl, pend_ctl_n;
  logic         pend_bad, pend_bad_n;
  logic         rdv_n;
  logic [W-1:0] rdd_n;

  assign commit_data = pend;

  always_comb begin
    st_n       = st;
    pend_n     = pend;
    pend_ctl_n = pend_ctl;
    pend_bad_n = pend_bad;
    commit_wip = 1'b0;
    commit_ctl = 1'b0;
    step_up    = 1'b0;
    step_dn    = 1'b0;
    rdv_n      = rd_req;
    rdd_n      = ONES;
    if (bus_rst) begin
      st_n       = S_IDLE;
      pend_n     = ZEROS;
      pend_ctl_n = 1'b0;
      pend_bad_n = 1'b0;
      rdv_n      = 1'b0;
    end else begin
      if (wr_valid) begin
        unique case (st)
          S_IDLE: ;
          S_CMD: begin
            unique case (wr_data)
              W'(OP_RD_POS):  st_n = S_RP_CTL;
              W'(OP_RD_CTL):  st_n = S_RC_CAPS;
              W'(OP_WR_POS):  begin st_n = S_W_DATA; pend_ctl_n = 1'b0; end
              W'(OP_WR_CTL):  begin st_n = S_W_DATA; pend_ctl_n = 1'b1; end
              W'(OP_STEP_UP): begin st_n = S_STEP_RD; step_up = 1'b1; end
              W'(OP_STEP_DN): begin st_n = S_STEP_RD; step_dn = 1'b1; end
              default:        st_n = S_TAIL1;
            endcase
          end
          S_W_DATA: begin
            pend_n     = wr_data;
            pend_bad_n = pend_ctl && (wr_data != W'(CTL_PUMP_OFF))
                                  && (wr_data != W'(CTL_PUMP_ON));
            st_n       = S_W_ECHO;
          end
          S_W_REL: begin
            if (wr_data == W'(RELEASE) && !pend_bad) begin
              commit_wip = !pend_ctl;
              commit_ctl = pend_ctl;
              st_n       = S_TAIL0;
            end else begin
              st_n       = S_TAIL1;
            end
          end
          default: ;
        endcase
      end
      if (rd_req) begin
        unique case (st)
          S_RP_CTL:  begin rdd_n = ctrl;  st_n = S_RP_WIP;  end
          S_RP_WIP:  begin rdd_n = wiper; st_n = S_TAIL0;   end
          S_RC_CAPS: begin rdd_n = W'(CAPS_BYTE); st_n = S_RC_CTL; end
          S_RC_CTL:  begin rdd_n = ctrl;  st_n = S_TAIL0;   end
          S_W_ECHO:  begin rdd_n = pend_bad ? ONES : pend; st_n = S_W_REL; end
          S_STEP_RD: begin rdd_n = wiper; st_n = S_CMD;     end
          S_TAIL0:   rdd_n = ZEROS;
          default:   rdd_n = ONES;
        endcase
      end
      if (st == S_IDLE && fn_enter) st_n = S_CMD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pend     <= ZEROS;
      pend_ctl <= 1'b0;
      pend_bad <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      st       <= st_n;
      pend     <= pend_n;
      pend_ctl <= pend_ctl_n;
      pend_bad <= pend_bad_n;
      rd_valid <= rdv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= ZEROS;
    else if (rd_req) rd_data <= rdd_n;
  end

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (st == S_IDLE));
  p_rd_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));
  p_bad_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !bus_rst && st == S_W_ECHO && pend_bad) |=> (rd_data == ONES));
endmodule

// File: rtl/digipot_fn.sv
module digipot_fn #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_rst,
  input  logic         fn_enter,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] wiper_code,
  output logic         pump_en,
  output logic         wiper_home
);
  import digipot_pkg::*;

  logic [W-1:0] ctrl;
  logic [W-1:0] commit_data;
  logic         commit_wip, commit_ctl, step_up, step_dn;

  digipot_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .fn_enter(fn_enter),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .wiper(wiper_code), .ctrl(ctrl),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .commit_wip(commit_wip), .commit_ctl(commit_ctl),
    .commit_data(commit_data), .step_up(step_up), .step_dn(step_dn)
  );

  digipot_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit_wip(commit_wip), .commit_ctl(commit_ctl),
    .commit_data(commit_data), .step_up(step_up), .step_dn(step_dn),
    .wiper(wiper_code), .ctrl(ctrl)
  );

  assign pump_en    = ctrl[PUMP_BIT];
  assign wiper_home = (wiper_code == '0);

  p_wiper_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid) |-> $stable(wiper_code));
  p_pump_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid) |-> $stable(pump_en));
endmodule

// File: tb/test_digipot_fn.sv
module test_digipot_fn;
  logic       clk = 1'b0;
  logic       rst_n, bus_rst, fn_enter, wr_valid, rd_req;
  logic [7:0] wr_data;
  logic       rd_valid, pump_en, wiper_home;
  logic [7:0] rd_data, wiper_code;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  digipot_fn i_digipot_fn (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .fn_enter(fn_enter),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .wiper_code(wiper_code),
    .pump_en(pump_en), .wiper_home(wiper_home)
  );

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected response %02h, expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s read got %02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s got %02h expected %02h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    wr_valid = 1'b1; wr_data = b;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic enter();
    bus_rst = 1'b1; @(posedge clk); #1; bus_rst = 1'b0;
    fn_enter = 1'b1; @(posedge clk); #1; fn_enter = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); #1; @(posedge clk); #1;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_rst = 1'b0; fn_enter = 1'b0;
    wr_valid = 1'b0; rd_req = 1'b0; wr_data = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state, R11 home flag
    chk("R1 wiper", wiper_code, 8'h00);
    chk("R1 pump", {7'd0, pump_en}, 8'h00);
    chk("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
    chk("R11 home at reset", {7'd0, wiper_home}, 8'h01);
    // R9 idle ignores bytes; R12 idle read gives ones
    wr(8'h0F); wr(8'h55); rd(8'hFF, "R12 idle read");
    settle();
    chk("R9 idle write ignored", wiper_code, 8'h00);
    // R2
    enter(); wr(8'hF0);
    rd(8'h0C, "R2 ctrl first"); rd(8'h00, "R2 wiper second"); rd(8'h00, "R2 zeros");
    // R3 and R1 control default
    enter(); wr(8'hAA);
    rd(8'hF3, "R3 caps"); rd(8'h0C, "R1 ctrl default"); rd(8'h00, "R3 zeros");
    // R12 read while a command byte is expected
    enter(); rd(8'hFF, "R12 read in command state");
    // R5 valid write
    enter(); wr(8'h55); wr(8'h4C); rd(8'h4C, "R5 echo");
    wr(8'h96); rd(8'h00, "R5 commit zeros");
    settle();
    chk("R5 pump on", {7'd0, pump_en}, 8'h01);
    // R5 invalid value never commits
    enter(); wr(8'h55); wr(8'h0D); rd(8'hFF, "R5 invalid echo");
    wr(8'h96); rd(8'hFF, "R5 invalid tail");
    settle();
    chk("R5 pump kept", {7'd0, pump_en}, 8'h01);
    enter(); wr(8'hAA); rd(8'hF3, "R3 caps again"); rd(8'h4C, "R5 ctrl unchanged");
    // R4 commit
    enter(); wr(8'h0F); wr(8'h7F); rd(8'h7F, "R4 echo");
    wr(8'h96); rd(8'h00, "R4 commit zeros");
    settle();
    chk("R4 wiper set", wiper_code, 8'h7F);
    chk("R11 home clear", {7'd0, wiper_home}, 8'h00);
    // R4 reject
    enter(); wr(8'h0F); wr(8'h22); rd(8'h22, "R4 echo2");
    wr(8'h95); rd(8'hFF, "R4 reject ones");
    settle();
    chk("R4 wiper kept", wiper_code, 8'h7F);
    // R9 abort discards pending
    enter(); wr(8'h0F); wr(8'h33);
    enter(); wr(8'hF0); rd(8'h4C, "R9 ctrl kept"); rd(8'h7F, "R9 wiper kept");
    // R6 R7 R8 stepping and chaining
    enter(); wr(8'hC3); rd(8'h80, "R6 inc");
    wr(8'hC3); rd(8'h81, "R8 chained inc");
    wr(8'h99); rd(8'h80, "R7 dec");
    wr(8'hF0); rd(8'h4C, "R8 chained read ctrl"); rd(8'h80, "R8 chained read wiper");
    // R6 saturation
    enter(); wr(8'h0F); wr(8'hFE); rd(8'hFE, "R4 echo FE"); wr(8'h96); rd(8'h00, "R4 commit FE");
    enter(); wr(8'hC3); rd(8'hFF, "R6 inc to max");
    wr(8'hC3); rd(8'hFF, "R6 inc saturates");
    settle();
    chk("R6 wiper max", wiper_code, 8'hFF);
    // R7 saturation
    enter(); wr(8'h0F); wr(8'h01); rd(8'h01, "R4 echo 01"); wr(8'h96); rd(8'h00, "R4 commit 01");
    enter(); wr(8'h99); rd(8'h00, "R7 dec to min");
    wr(8'h99); rd(8'h00, "R7 dec saturates");
    settle();
    chk("R7 wiper min", wiper_code, 8'h00);
    chk("R11 home again", {7'd0, wiper_home}, 8'h01);
    // R10 unknown command
    enter(); wr(8'h12); rd(8'hFF, "R10 ones"); rd(8'hFF, "R10 ones again");
    wr(8'hC3); rd(8'hFF, "R10 write ignored");
    settle();
    chk("R10 wiper untouched", wiper_code, 8'h00);
    settle();
    chk("R12 no leftover", exp_q.size()[7:0], 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule